// File: doc/BRIEF.md
# Memory Clock Parameter Loader

This block sits behind a pair of host I/O ports and holds the three loop-parameter registers of a memory clock synthesizer. The host first writes a register index to the index port, then reads or writes the selected register through the data port next to it. Writes land in shadow copies. The values that drive the synthesizer, called the active set, change only when the three registers have been written in a strict low, middle, high order. A write that breaks the order cannot push a half-written set of parameters into the synthesizer.

The high register carries two fields. The top bit chooses the clock source: the fixed default frequency or the programmed loop. Three code bits choose a power-of-two post divider. The block presents the committed loop words, the source select, the raw divider code and a decoded divide factor. It raises a one-cycle pulse on each commit. It also raises a one-cycle flag when software changes the divider code without first dropping the source select back to the default.

Top module: `mclk_param_loader`

## Requirements
- R1: After a synchronous active-high reset, the index, all shadow words, all active outputs and `bus_rdata` are zero, `pdiv_factor` is 1, and `params_upd` and `cfg_violation` are low.
- R2: A write to address 3D6h stores the index. A write to address 3D7h stores the data into the shadow word at that index. Address 3D6h reads back the index and 3D7h reads back the shadow word, with `bus_rdata` valid in the cycle after the read strobe.
- R3: The active outputs hold their values until data-port writes to indices CCh, CDh and CEh complete in that order. On the final write, `loop_cc`, `loop_cd`, `mclk_sel` and `pdiv_code` all take the new values at the same clock edge, and `params_upd` is high for exactly that one cycle.
- R4: A write to CCh always restarts the sequence. A write to CDh that does not directly follow a CCh write, or a write to CEh that does not directly follow a CDh write, returns the tracker to waiting for CCh and commits nothing.
- R5: Bit 7 of the committed CEh word drives `mclk_sel` (0 selects the default frequency, 1 selects the programmed loop). Bits 6 to 4 drive `pdiv_code`.
- R6: A committed code of 0 to 5 sets `pdiv_factor` to 2 to the power of the code (1, 2, 4, 8, 16 or 32), updated on the same edge as the commit pulse.
- R7: A reserved code (6 or 7) is stored and committed as written, but `pdiv_factor` keeps its previous value.
- R8: Bits 3 to 0 of the CEh word are not stored. They read back as 0.
- R9: A data write is ignored, and a data read returns zero, when the index is outside CCh to CEh. Such writes leave the shadow words and the tracker as they were. Bus accesses to any other address are also ignored.
- R10: `cfg_violation` pulses for one cycle after a write to CEh whose bits 6 to 4 differ from the stored bits while the stored bit 7 is 1. The write itself still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | I/O address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| loop_cc | output | 8 | Committed loop word from index CCh |
| loop_cd | output | 8 | Committed loop word from index CDh |
| mclk_sel | output | 1 | Committed clock source select |
| pdiv_code | output | 3 | Committed post divider code |
| pdiv_factor | output | 6 | Decoded post divide factor |
| params_upd | output | 1 | One-cycle commit pulse |
| cfg_violation | output | 1 | One-cycle select-ordering violation flag |

## Verification
A commit and a violation flag can come from the same CEh write. This happens when the write completes the ordered sequence while the stored select bit is 1 and the write changes the divider code. The bench sets the stored select bit with an out-of-order CEh write, which commits nothing. It then runs a full sequence whose final word has a different code. In the cycle after that write it requires both `params_upd` and `cfg_violation` high, and the scoreboard requires the committed values to match the new word.

// File: rtl/mclk_ldr_pkg.sv
package mclk_ldr_pkg;
  localparam int REG_W     = 8;
  localparam int NUM_SLOTS = 3;
  localparam int SLOT_W    = 2;
  localparam int SEL_BIT   = 7;
  localparam int CODE_LSB  = 4;
  localparam int CODE_W    = 3;
  localparam int MAX_CODE  = 5;
  localparam int FACT_W    = MAX_CODE + 1;
  localparam logic [REG_W-1:0] HI_KEEP = 8'hF0;

  localparam logic [SLOT_W-1:0] SLOT_LO  = 2'd0;
  localparam logic [SLOT_W-1:0] SLOT_MID = 2'd1;
  localparam logic [SLOT_W-1:0] SLOT_HI  = 2'd2;

  typedef enum logic [1:0] {
    TRK_WANT_LO  = 2'd0,
    TRK_WANT_MID = 2'd1,
    TRK_WANT_HI  = 2'd2
  } trk_t;
endpackage

// File: rtl/mclk_port_decode.sv
module mclk_port_decode
  import mclk_ldr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT  = 16'h03D6,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h03D7,
  parameter logic [REG_W-1:0]  BASE_IDX  = 8'hCC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  idx_q,
  output logic [SLOT_W-1:0] slot,
  output logic              slot_hit,
  output logic              data_wr,
  output logic              data_rd,
  output logic              idx_rd
);
  logic [REG_W-1:0] offset;

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else if (bus_wr && bus_addr == IDX_PORT) idx_q <= bus_wdata;
  end

  always_comb begin
    offset   = idx_q - BASE_IDX;
    slot_hit = (idx_q >= BASE_IDX) && (offset < REG_W'(NUM_SLOTS));
    slot     = slot_hit ? offset[SLOT_W-1:0] : SLOT_W'(NUM_SLOTS);
    data_wr  = bus_wr && (bus_addr == DATA_PORT) && slot_hit;
    data_rd  = bus_rd && (bus_addr == DATA_PORT);
    idx_rd   = bus_rd && (bus_addr == IDX_PORT);
  end
endmodule

// File: rtl/mclk_seq_tracker.sv
module mclk_seq_tracker
  import mclk_ldr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] slot,
  output logic              commit
);
  trk_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    commit  = 1'b0;
    if (wr_en) begin
      case (slot)
        SLOT_LO:  state_d = TRK_WANT_MID;
        SLOT_MID: state_d = (state_q == TRK_WANT_MID) ? TRK_WANT_HI : TRK_WANT_LO;
        SLOT_HI: begin
          commit  = (state_q == TRK_WANT_HI);
          state_d = TRK_WANT_LO;
        end
        default:  state_d = TRK_WANT_LO;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= TRK_WANT_LO;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/mclk_shadow_bank.sv
module mclk_shadow_bank
  import mclk_ldr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] slot,
  input  logic              slot_hit,
  input  logic [REG_W-1:0]  wdata,
  input  logic              rd_data,
  input  logic              rd_idx,
  input  logic [REG_W-1:0]  idx_q,
  output logic [REG_W-1:0]  sh_lo,
  output logic [REG_W-1:0]  sh_mid,
  output logic [REG_W-1:0]  hi_next,
  output logic [REG_W-1:0]  rdata_q,
  output logic              viol_q
);
  localparam int ARR_N = 1 << SLOT_W;

  logic [REG_W-1:0] sh_arr [ARR_N];

  for (genvar gi = 0; gi < ARR_N; gi++) begin : g_slot
    if (gi < NUM_SLOTS) begin : g_reg
      localparam logic [REG_W-1:0] KEEP = (gi == int'(SLOT_HI)) ? HI_KEEP : '1;
      logic [REG_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (wr_en && slot == SLOT_W'(gi)) q <= wdata & KEEP;
      end
      assign sh_arr[gi] = q;
    end else begin : g_zero
      assign sh_arr[gi] = '0;
    end
  end

  assign sh_lo   = sh_arr[SLOT_LO];
  assign sh_mid  = sh_arr[SLOT_MID];
  assign hi_next = wdata & HI_KEEP;

  logic hi_sel_set, code_moves;
  assign hi_sel_set = sh_arr[SLOT_HI][SEL_BIT];
  assign code_moves = wdata[CODE_LSB +: CODE_W] != sh_arr[SLOT_HI][CODE_LSB +: CODE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      viol_q  <= 1'b0;
    end else begin
      if (rd_idx)       rdata_q <= idx_q;
      else if (rd_data) rdata_q <= slot_hit ? sh_arr[slot] : '0;
      viol_q <= wr_en && (slot == SLOT_HI) && hi_sel_set && code_moves;
    end
  end
endmodule

// File: rtl/mclk_pdiv_decode.sv
module mclk_pdiv_decode
  import mclk_ldr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  output logic [FACT_W-1:0] factor_q
);
  logic code_ok;
  assign code_ok = int'(code) <= MAX_CODE;

  always_ff @(posedge clk) begin
    if (rst) factor_q <= FACT_W'(1);
    else if (load && code_ok) factor_q <= FACT_W'(1) << code;
  end
endmodule

// File: rtl/mclk_param_loader.sv
module mclk_param_loader
  import mclk_ldr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT  = 16'h03D6,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h03D7,
  parameter logic [7:0]        BASE_IDX  = 8'hCC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [7:0]        loop_cc,
  output logic [7:0]        loop_cd,
  output logic              mclk_sel,
  output logic [2:0]        pdiv_code,
  output logic [5:0]        pdiv_factor,
  output logic              params_upd,
  output logic              cfg_violation
);
  logic [REG_W-1:0]  idx_q;
  logic [SLOT_W-1:0] slot;
  logic              slot_hit, data_wr, data_rd, idx_rd, commit;
  logic [REG_W-1:0]  sh_lo, sh_mid, hi_next;

  mclk_port_decode #(
    .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT), .BASE_IDX(BASE_IDX)
  ) u_dec (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .idx_q(idx_q), .slot(slot), .slot_hit(slot_hit),
    .data_wr(data_wr), .data_rd(data_rd), .idx_rd(idx_rd)
  );

  mclk_seq_tracker u_trk (
    .clk(clk), .rst(rst), .wr_en(data_wr), .slot(slot), .commit(commit)
  );

  mclk_shadow_bank u_shd (
    .clk(clk), .rst(rst), .wr_en(data_wr), .slot(slot), .slot_hit(slot_hit),
    .wdata(bus_wdata), .rd_data(data_rd), .rd_idx(idx_rd), .idx_q(idx_q),
    .sh_lo(sh_lo), .sh_mid(sh_mid), .hi_next(hi_next),
    .rdata_q(bus_rdata), .viol_q(cfg_violation)
  );

  mclk_pdiv_decode u_pdiv (
    .clk(clk), .rst(rst), .load(commit),
    .code(hi_next[CODE_LSB +: CODE_W]), .factor_q(pdiv_factor)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      loop_cc    <= '0;
      loop_cd    <= '0;
      mclk_sel   <= 1'b0;
      pdiv_code  <= '0;
      params_upd <= 1'b0;
    end else begin
      params_upd <= commit;
      if (commit) begin
        loop_cc   <= sh_lo;
        loop_cd   <= sh_mid;
        mclk_sel  <= hi_next[SEL_BIT];
        pdiv_code <= hi_next[CODE_LSB +: CODE_W];
      end
    end
  end
endmodule

// File: rtl/mclk_param_loader_chk.sv
module mclk_param_loader_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h03D7
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        loop_cc,
  input logic [7:0]        loop_cd,
  input logic              mclk_sel,
  input logic [2:0]        pdiv_code,
  input logic [5:0]        pdiv_factor,
  input logic              params_upd,
  input logic              cfg_violation
);
  a_r3_upd_single: assert property (@(posedge clk) disable iff (rst)
    params_upd |=> !params_upd);

  a_r3_active_hold: assert property (@(posedge clk) disable iff (rst)
    !params_upd |-> ($stable(loop_cc) && $stable(loop_cd) && $stable(mclk_sel) && $stable(pdiv_code)));

  a_r3_upd_after_write: assert property (@(posedge clk) disable iff (rst)
    params_upd |-> $past(bus_wr && bus_addr == DATA_PORT));

  a_r6_factor_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(pdiv_factor) == 1);

  a_r6_factor_only_on_upd: assert property (@(posedge clk) disable iff (rst)
    !params_upd |-> $stable(pdiv_factor));

  a_r7_reserved_hold: assert property (@(posedge clk) disable iff (rst)
    (params_upd && pdiv_code > 3'd5) |-> $stable(pdiv_factor));

  a_r10_after_write: assert property (@(posedge clk) disable iff (rst)
    cfg_violation |-> $past(bus_wr && bus_addr == DATA_PORT));
endmodule

bind mclk_param_loader mclk_param_loader_chk #(.ADDR_W(ADDR_W), .DATA_PORT(DATA_PORT)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .loop_cc(loop_cc), .loop_cd(loop_cd), .mclk_sel(mclk_sel), .pdiv_code(pdiv_code),
  .pdiv_factor(pdiv_factor), .params_upd(params_upd), .cfg_violation(cfg_violation)
);

// File: tb/mclk_param_loader_tb.sv
module mclk_param_loader_tb;
  localparam logic [15:0] P_IDX  = 16'h03D6;
  localparam logic [15:0] P_DATA = 16'h03D7;
  localparam logic [7:0]  IX_LO  = 8'hCC;
  localparam logic [7:0]  IX_MID = 8'hCD;
  localparam logic [7:0]  IX_HI  = 8'hCE;

  typedef struct packed {
    logic [7:0] cc;
    logic [7:0] cd;
    logic       sel;
    logic [2:0] code;
    logic [5:0] fac;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, loop_cc, loop_cd;
  logic mclk_sel, params_upd, cfg_violation;
  logic [2:0] pdiv_code;
  logic [5:0] pdiv_factor;

  int checks = 0;
  int errors = 0;
  item_t sb_q[$];
  item_t mon_item;
  logic [5:0] exp_fac = 6'd1;
  logic [7:0] rd_v;

  always #4 clk = ~clk;

  mclk_param_loader u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .loop_cc(loop_cc), .loop_cd(loop_cd),
    .mclk_sel(mclk_sel), .pdiv_code(pdiv_code), .pdiv_factor(pdiv_factor),
    .params_upd(params_upd), .cfg_violation(cfg_violation)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic io_rd(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
    io_wr(P_IDX, idx);
    io_wr(P_DATA, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
    io_wr(P_IDX, idx);
    io_rd(P_DATA, d);
  endtask

  task automatic push_exp(input logic [7:0] cc, input logic [7:0] cd, input logic [7:0] ce);
    item_t it;
    if (ce[6:4] <= 3'd5) exp_fac = 6'd1 << ce[6:4];
    it.cc = cc; it.cd = cd; it.sel = ce[7]; it.code = ce[6:4]; it.fac = exp_fac;
    sb_q.push_back(it);
  endtask

  task automatic full_seq(input logic [7:0] cc, input logic [7:0] cd, input logic [7:0] ce);
    push_exp(cc, cd, ce);
    reg_wr(IX_LO, cc);
    reg_wr(IX_MID, cd);
    reg_wr(IX_HI, ce);
  endtask

  always @(negedge clk) begin
    if (!rst && params_upd) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4 unexpected commit actual=1 expected=0");
      end else begin
        mon_item = sb_q.pop_front();
        chk("R3 commit loop_cc", 32'(loop_cc), 32'(mon_item.cc));
        chk("R3 commit loop_cd", 32'(loop_cd), 32'(mon_item.cd));
        chk("R5 commit mclk_sel", 32'(mclk_sel), 32'(mon_item.sel));
        chk("R5 commit pdiv_code", 32'(pdiv_code), 32'(mon_item.code));
        chk("R6/R7 commit pdiv_factor", 32'(pdiv_factor), 32'(mon_item.fac));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", 32'(bus_rdata), 0);
    chk("R1 loop_cc", 32'(loop_cc), 0);
    chk("R1 loop_cd", 32'(loop_cd), 0);
    chk("R1 sel", 32'(mclk_sel), 0);
    chk("R1 code", 32'(pdiv_code), 0);
    chk("R1 factor", 32'(pdiv_factor), 1);
    chk("R1 upd", 32'(params_upd), 0);
    chk("R1 viol", 32'(cfg_violation), 0);
    io_rd(P_IDX, rd_v);
    chk("R1 index", 32'(rd_v), 0);

    // R3 ordered sequence, active held until the last write
    push_exp(8'h11, 8'h22, 8'hA5);
    reg_wr(IX_LO, 8'h11);
    reg_wr(IX_MID, 8'h22);
    chk("R3 held before CE", 32'(loop_cc), 0);
    chk("R3 no upd before CE", 32'(params_upd), 0);
    reg_wr(IX_HI, 8'hA5);
    chk("R3 upd pulse", 32'(params_upd), 1);
    chk("R10 no viol when sel clear", 32'(cfg_violation), 0);
    @(negedge clk);
    chk("R3 upd one cycle", 32'(params_upd), 0);

    // R2 / R8 read back
    reg_rd(IX_HI, rd_v);
    chk("R8 CE low bits zero", 32'(rd_v), 32'h A0);
    reg_rd(IX_LO, rd_v);
    chk("R2 read CC", 32'(rd_v), 32'h11);
    reg_rd(IX_MID, rd_v);
    chk("R2 read CD", 32'(rd_v), 32'h22);
    io_rd(P_IDX, rd_v);
    chk("R2 read index", 32'(rd_v), 32'(IX_MID));

    // R4 out-of-order sequences commit nothing
    reg_wr(IX_MID, 8'h33);
    reg_wr(IX_HI, 8'hA0);
    chk("R4 CD,CE no commit", 32'(loop_cd), 32'h22);
    reg_wr(IX_LO, 8'h44);
    reg_wr(IX_HI, 8'hA0);
    chk("R4 CC,CE no commit", 32'(loop_cc), 32'h11);
    reg_wr(IX_LO, 8'h44);
    reg_wr(IX_MID, 8'h55);
    reg_wr(IX_MID, 8'h55);
    reg_wr(IX_HI, 8'hA0);
    chk("R4 CC,CD,CD,CE no commit", 32'(loop_cc), 32'h11);

    // R4 a CC write restarts the sequence
    reg_wr(IX_LO, 8'h01);
    reg_wr(IX_MID, 8'h02);
    full_seq(8'h03, 8'h04, 8'hA0);
    chk("R4 restart commit", 32'(loop_cc), 32'h03);

    // R9 out-of-range index and stray address
    reg_wr(IX_LO, 8'h05);
    reg_wr(8'h10, 8'h77);
    io_wr(16'h03D5, 8'h99);
    push_exp(8'h05, 8'h06, 8'hA0);
    reg_wr(IX_MID, 8'h06);
    reg_wr(IX_HI, 8'hA0);
    chk("R9 tracker untouched, commit", 32'(loop_cd), 32'h06);
    reg_rd(8'h10, rd_v);
    chk("R9 read idx 10h", 32'(rd_v), 0);
    reg_rd(8'hCB, rd_v);
    chk("R9 read idx CBh", 32'(rd_v), 0);
    reg_rd(8'hCF, rd_v);
    chk("R9 read idx CFh", 32'(rd_v), 0);
    reg_rd(IX_LO, rd_v);
    chk("R9 CC shadow kept", 32'(rd_v), 32'h05);

    // R10 violation behaviour (stored CE = A0, bit7 set)
    reg_wr(IX_HI, 8'hB0);
    chk("R10 viol on code change", 32'(cfg_violation), 1);
    reg_wr(IX_HI, 8'hB0);
    chk("R10 no viol same code", 32'(cfg_violation), 0);
    reg_wr(IX_HI, 8'h30);
    chk("R10 no viol clearing sel", 32'(cfg_violation), 0);
    reg_wr(IX_HI, 8'h40);
    chk("R10 no viol sel clear", 32'(cfg_violation), 0);
    reg_rd(IX_HI, rd_v);
    chk("R10 write still stored", 32'(rd_v), 32'h40);

    // R10 + R3 in the same cycle
    reg_wr(IX_HI, 8'hC0);
    full_seq(8'h07, 8'h08, 8'hD0);
    chk("R10 viol with commit", 32'(cfg_violation), 1);
    chk("R3 upd with viol", 32'(params_upd), 1);

    // R7 reserved codes
    full_seq(8'h09, 8'h0A, 8'hE0);
    chk("R7 factor held code6", 32'(pdiv_factor), 32);
    chk("R7 code6 committed", 32'(pdiv_code), 6);
    reg_rd(IX_HI, rd_v);
    chk("R7 code6 stored", 32'(rd_v), 32'hE0);
    full_seq(8'h0B, 8'h0C, 8'hF0);
    chk("R7 factor held code7", 32'(pdiv_factor), 32);

    // R6 decode sweep
    for (int k = 0; k < 6; k++) begin
      full_seq(8'(k), 8'(k + 1), {1'b0, 3'(k), 4'h0});
      chk("R6 factor sweep", 32'(pdiv_factor), 32'(1) << k);
    end
    chk("R5 sel cleared", 32'(mclk_sel), 0);

    repeat (3) @(negedge clk);
    chk("R3 all expected commits seen", 32'(sb_q.size()), 0);
    finish_run();
  end
endmodule